// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Registered Status Flags

This block is the execution datapath of a small 8-bit accumulator machine. Each cycle it takes an operation code, the accumulator value, a second operand and the stored status flags. It returns a combinational result and a strobe that says whether the result belongs in the accumulator. At the clock edge it updates its own five-flag register: sign, zero, auxiliary carry, parity and carry.

The operations are:
- add, add-with-carry, subtract, subtract-with-borrow and compare;
- increment and decrement;
- AND, OR, XOR and complement;
- rotate-left and rotate-right, each in a circular form and a through-carry form;
- set-carry and complement-carry;
- decimal adjust.

Each operation class writes its own subset of the flags. The register has a separate write enable for the carry bit and for the other four bits. Instruction decode, register selection and memory access sit outside the block. The surrounding machine drives `op_code` and the operands, pulses `exec_en` for each executed operation, and writes `result_o` back when `acc_we_o` is high.

Top module: `alu8_status`

## Requirements
- R1: On the clock edge where `rst` is high, `flags_o` becomes 0.
- R2: `flags_o` has carry at bit 0, parity at bit 1, auxiliary carry at bit 2, zero at bit 3 and sign at bit 4. The register changes only at a rising edge where `exec_en` is high. With `exec_en` low it holds its value.
- R3: For every operation that writes the sign, zero and parity flags, the new values are taken from `result_o`. Sign is result bit 7. Zero is 1 when the result is 0x00. Parity is 1 when the result has an even number of one bits.
- R4: Codes 0 (add) and 1 (add-with-carry) give result = A + B (+ stored carry for code 1), modulo 256. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3, so 0x0F + 0x08 = 0x17 sets it.
- R5: Codes 2 (subtract) and 3 (subtract-with-borrow) give result = A − B (− stored carry for code 3), modulo 256. Carry is 1 when B (plus the borrow-in) is greater than A. Auxiliary carry is 1 when the low nibble borrows.
- R6: Code 4 (compare) sets all five flags exactly as code 2 would, and drives `acc_we_o` low.
- R7: Codes 5 (increment) and 6 (decrement) give A+1 and A−1. Auxiliary carry is the nibble carry or borrow. Sign, zero and parity follow R3. Carry keeps its stored value.
- R8: Codes 7, 8 and 9 (AND, OR, XOR with B) clear carry and auxiliary carry. The other three flags follow R3.
- R9: Code 11 rotates A left and copies bit 7 into both bit 0 and carry. Code 12 rotates A right and copies bit 0 into both bit 7 and carry. Only carry changes.
- R10: Code 13 rotates left through carry: the old carry goes to bit 0 and bit 7 goes to carry. Code 14 rotates right through carry: the old carry goes to bit 7 and bit 0 goes to carry. Only carry changes.
- R11: Code 10 returns the bitwise complement of A and changes no flag. Code 15 sets carry to 1. Code 16 inverts carry. Codes 15 and 16 drive `acc_we_o` low and leave the other four flags unchanged.
- R12: Code 17 (decimal adjust) adds 0x06 when A[3:0] > 9 or auxiliary carry is set. It then adds 0x60 when the intermediate high nibble is > 9, when carry is set, or when the first addition overflowed. Carry becomes old carry OR the second correction. Auxiliary carry becomes (A[3:0] > 9). The other flags follow R3.
- R13: Codes 18 to 31 drive `acc_we_o` low and leave `flags_o` unchanged even when `exec_en` is high.
- R14: `acc_we_o` is high for codes 0–3, 5–14 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| exec_en | input | 1 | Commit the flag update of this cycle's operation |
| op_code | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand (A) |
| opnd_in | input | 8 | Second operand (B) |
| result_o | output | 8 | Combinational result |
| acc_we_o | output | 1 | High when `result_o` is meant for the accumulator |
| flags_o | output | 5 | Registered flags {sign, zero, aux, parity, carry} |

## Verification
`result_o` and `acc_we_o` are combinational. They depend on the inputs and the flags already stored, so they are due in the same cycle the operands are applied. The bench drives inputs just after a falling edge and compares these two outputs one nanosecond later, against a behavioural model that uses the model's current flags. The new flag values are due after exactly one register, at the next rising edge. The bench compares `flags_o` one nanosecond after that edge and then advances its model state, so every operation is checked in the cycle it issues and again in the cycle its flags land.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    localparam int DATA_W  = 8;
    localparam int NIB_W   = DATA_W / 2;
    localparam int OP_W    = 5;
    localparam int FLAG_N  = 5;
    localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);
    localparam logic [DATA_W-1:0] LO_FIX = DATA_W'(8'h06);
    localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(8'h60);

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
        OP_CMP = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_AND = 5'd7,
        OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_NOT = 5'd10, OP_RLC = 5'd11,
        OP_RRC = 5'd12, OP_RAL = 5'd13, OP_RAR = 5'd14, OP_STC = 5'd15,
        OP_CMC = 5'd16, OP_DAA = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic sgn;
        logic zer;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    typedef enum logic [1:0] {
        FC_NONE, FC_CARRY, FC_NOCARRY, FC_ALL
    } fclass_t;

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction

    function automatic fclass_t class_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
            OP_AND, OP_OR, OP_XOR, OP_DAA:         return FC_ALL;
            OP_INC, OP_DEC:                        return FC_NOCARRY;
            OP_RLC, OP_RRC, OP_RAL, OP_RAR,
            OP_STC, OP_CMC:                        return FC_CARRY;
            default:                               return FC_NONE;
        endcase
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
            OP_INC, OP_DEC, OP_DAA: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic writes_acc(input alu_op_e op);
        case (op)
            OP_CMP, OP_STC, OP_CMC: return 1'b0;
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC,
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_RLC, OP_RRC,
            OP_RAL, OP_RAR, OP_DAA: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              aux_in,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              ac
);
    logic [DATA_W:0]  wide;
    logic [NIB_W:0]   nib;
    logic [DATA_W:0]  stage1;
    logic             ci;
    logic             lo_adj;
    logic             hi_adj;

    always_comb begin
        wide   = '0;
        nib    = '0;
        stage1 = '0;
        ci     = 1'b0;
        lo_adj = 1'b0;
        hi_adj = 1'b0;
        res    = a;
        cy     = cin;
        ac     = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                ci   = (op == OP_ADC) ? cin : 1'b0;
                wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
                nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
                res  = wide[DATA_W-1:0];
                cy   = wide[DATA_W];
                ac   = nib[NIB_W];
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                ci   = (op == OP_SBB) ? cin : 1'b0;
                wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, ci};
                nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, ci};
                res  = wide[DATA_W-1:0];
                cy   = wide[DATA_W];
                ac   = nib[NIB_W];
            end
            OP_INC: begin
                wide = {1'b0, a} + 1'b1;
                nib  = {1'b0, a[NIB_W-1:0]} + 1'b1;
                res  = wide[DATA_W-1:0];
                ac   = nib[NIB_W];
            end
            OP_DEC: begin
                wide = {1'b0, a} - 1'b1;
                nib  = {1'b0, a[NIB_W-1:0]} - 1'b1;
                res  = wide[DATA_W-1:0];
                ac   = nib[NIB_W];
            end
            OP_DAA: begin
                lo_adj = (a[NIB_W-1:0] > BCD_MAX) || aux_in;
                stage1 = {1'b0, a} + {1'b0, (lo_adj ? LO_FIX : '0)};
                hi_adj = (stage1[DATA_W-1:NIB_W] > BCD_MAX) || cin || stage1[DATA_W];
                res    = stage1[DATA_W-1:0] + (hi_adj ? HI_FIX : '0);
                cy     = cin | hi_adj;
                ac     = a[NIB_W-1:0] > BCD_MAX;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cy
);
    always_comb begin
        res = a;
        cy  = cin;
        case (op)
            OP_AND: begin res = a & b; cy = 1'b0; end
            OP_OR:  begin res = a | b; cy = 1'b0; end
            OP_XOR: begin res = a ^ b; cy = 1'b0; end
            OP_NOT: res = ~a;
            OP_RLC: begin res = {a[DATA_W-2:0], a[DATA_W-1]}; cy = a[DATA_W-1]; end
            OP_RRC: begin res = {a[0], a[DATA_W-1:1]};        cy = a[0];        end
            OP_RAL: begin res = {a[DATA_W-2:0], cin};         cy = a[DATA_W-1]; end
            OP_RAR: begin res = {cin, a[DATA_W-1:1]};         cy = a[0];        end
            OP_STC: cy = 1'b1;
            OP_CMC: cy = ~cin;
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
`timescale 1ns/1ps
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cy_we,
    input  logic   rest_we,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (cy_we) q.cry <= d.cry;
            if (rest_we) begin
                q.sgn <= d.sgn;
                q.zer <= d.zer;
                q.aux <= d.aux;
                q.par <= d.par;
            end
        end
    end
endmodule

// File: rtl/alu8_status.sv
`timescale 1ns/1ps
module alu8_status
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_we_o,
    output logic [FLAG_N-1:0] flags_o
);
    alu_op_e           op;
    fclass_t           fcls;
    flags_t            cur;
    flags_t            nxt;
    logic [DATA_W-1:0] ar_res, lg_res;
    logic              ar_cy, ar_ac, lg_cy;
    logic              arith_sel;

    assign op        = alu_op_e'(op_code);
    assign fcls      = class_of(op);
    assign arith_sel = is_arith(op);

    alu8_arith u_arith (
        .op(op), .a(acc_in), .b(opnd_in), .cin(cur.cry), .aux_in(cur.aux),
        .res(ar_res), .cy(ar_cy), .ac(ar_ac)
    );

    alu8_logic u_logic (
        .op(op), .a(acc_in), .b(opnd_in), .cin(cur.cry),
        .res(lg_res), .cy(lg_cy)
    );

    always_comb begin
        result_o = arith_sel ? ar_res : lg_res;
        acc_we_o = writes_acc(op);
        nxt.sgn  = result_o[DATA_W-1];
        nxt.zer  = (result_o == '0);
        nxt.par  = even_parity(result_o);
        nxt.aux  = arith_sel ? ar_ac : 1'b0;
        nxt.cry  = arith_sel ? ar_cy : lg_cy;
    end

    alu8_flagreg u_flags (
        .clk(clk), .rst(rst),
        .cy_we(exec_en && (fcls == FC_ALL || fcls == FC_CARRY)),
        .rest_we(exec_en && (fcls == FC_ALL || fcls == FC_NOCARRY)),
        .d(nxt), .q(cur)
    );

    assign flags_o = cur;
endmodule

// File: rtl/alu8_status_chk.sv
`timescale 1ns/1ps
module alu8_status_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exec_en,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [DATA_W-1:0] result_o,
    input logic              acc_we_o,
    input logic [FLAG_N-1:0] flags_o
);
    logic full_upd, keep_cy, no_upd;
    assign full_upd = (op_code <= 5'd4) || (op_code >= 5'd7 && op_code <= 5'd9) || op_code == 5'd17;
    assign keep_cy  = (op_code == 5'd5) || (op_code == 5'd6);
    assign no_upd   = (op_code == 5'd10) || (op_code >= 5'd18);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> flags_o == '0); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(flags_o)); // R2
    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (full_upd || keep_cy)) |=> flags_o[4] == $past(result_o[7])); // R3
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (full_upd || keep_cy)) |=> flags_o[3] == ($past(result_o) == 8'h00)); // R3
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_code == 5'd4) |-> !acc_we_o); // R6
    AST_INCDEC_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
        (exec_en && keep_cy) |=> flags_o[0] == $past(flags_o[0])); // R7
    AST_NOUPD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (exec_en && no_upd) |=> $stable(flags_o)); // R13
    AST_SETCY_ONE: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_code == 5'd15) |=> flags_o[0]); // R11
endmodule

bind alu8_status alu8_status_chk u_chk (.*);

// File: tb/alu8_status_test.sv
`timescale 1ns/1ps
module alu8_status_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       exec_en;
    logic [4:0] op_code;
    logic [7:0] acc_in, opnd_in;
    logic [7:0] result_o;
    logic       acc_we_o;
    logic [4:0] flags_o;

    int total = 0;
    int bad   = 0;
    logic [4:0] mflags;
    bit finished = 0;

    always #2 clk = ~clk;

    alu8_status uut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .result_o(result_o),
        .acc_we_o(acc_we_o), .flags_o(flags_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:         return "R4";
            2, 3:         return "R5";
            4:            return "R6";
            5, 6:         return "R7";
            7, 8, 9:      return "R8";
            11, 12:       return "R9";
            13, 14:       return "R10";
            10, 15, 16:   return "R11";
            17:           return "R12";
            default:      return "R13";
        endcase
    endfunction

    function automatic int even1(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) & 1) n++;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    // returns {result[7:0], we, flags[4:0]}
    function automatic logic [13:0] model(input int op, input int a, input int b, input logic [4:0] f);
        int r, c, ax, cy, ac, t, lo, hi;
        int we;
        int upd; // 0 none,1 carry only,2 no carry,3 all
        c  = f[0]; ax = f[2];
        r = a; cy = c; ac = ax; upd = 0; we = 1;
        case (op)
            0, 1: begin
                t = (op == 1) ? c : 0;
                r = a + b + t; cy = (r > 255); ac = ((a % 16) + (b % 16) + t) > 15; upd = 3;
            end
            2, 3, 4: begin
                t = (op == 3) ? c : 0;
                r = a - b - t; cy = (r < 0); ac = ((a % 16) - (b % 16) - t) < 0; upd = 3;
                if (r < 0) r += 256;
                if (op == 4) we = 0;
            end
            5: begin r = (a + 1) % 256; ac = (a % 16) == 15; upd = 2; end
            6: begin r = (a + 255) % 256; ac = (a % 16) == 0; upd = 2; end
            7: begin r = a & b; cy = 0; ac = 0; upd = 3; end
            8: begin r = a | b; cy = 0; ac = 0; upd = 3; end
            9: begin r = a ^ b; cy = 0; ac = 0; upd = 3; end
            10: begin r = 255 - a; end
            11: begin cy = a / 128; r = ((a * 2) % 256) + cy; upd = 1; end
            12: begin cy = a % 2; r = (a / 2) + cy * 128; upd = 1; end
            13: begin cy = a / 128; r = ((a * 2) % 256) + c; upd = 1; end
            14: begin cy = a % 2; r = (a / 2) + c * 128; upd = 1; end
            15: begin cy = 1; upd = 1; we = 0; end
            16: begin cy = 1 - c; upd = 1; we = 0; end
            17: begin
                lo = ((a % 16) > 9) || (ax == 1);
                t  = a + (lo ? 6 : 0);
                hi = (((t % 256) / 16) > 9) || (c == 1) || (t > 255);
                r  = ((t % 256) + (hi ? 96 : 0)) % 256;
                cy = (c == 1) || hi;
                ac = (a % 16) > 9;
                upd = 3;
            end
            default: we = 0;
        endcase
        r = r % 256;
        begin
            logic [4:0] nf;
            nf = f;
            if (upd == 1 || upd == 3) nf[0] = cy[0];
            if (upd >= 2) begin
                nf[1] = even1(r)[0];
                nf[2] = ac[0];
                nf[3] = (r == 0);
                nf[4] = r[7];
            end
            return {r[7:0], we[0], nf};
        end
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int op, input int a, input int b, input bit ex);
        logic [13:0] m;
        @(negedge clk);
        op_code = op[4:0]; acc_in = a[7:0]; opnd_in = b[7:0]; exec_en = ex;
        #1;
        m = model(op, a, b, mflags);
        chk(req_of(op), "result", result_o, m[13:6]);
        chk((op == 4) ? "R6" : "R14", "acc_we", acc_we_o, m[5]);
        @(posedge clk);
        #1;
        if (ex) mflags = m[4:0];
        chk(ex ? req_of(op) : "R2", "flags", flags_o, mflags);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; exec_en = 0; op_code = 0; acc_in = 0; opnd_in = 0;
        mflags = 5'h00;
        repeat (3) @(posedge clk);
        #1 chk("R1", "reset flags", flags_o, 0);
        @(negedge clk) rst = 1'b0;

        step(0, 8'h0F, 8'h08, 1);   // R4 aux carry 0x17
        step(0, 8'hFF, 8'h01, 1);   // R4 carry + zero
        step(1, 8'h10, 8'h20, 1);   // R4 adc with carry in
        step(2, 8'h10, 8'h01, 1);   // R5 nibble borrow
        step(3, 8'h05, 8'h05, 1);   // R5 sbb
        step(2, 8'h01, 8'h02, 1);   // R5 borrow
        step(4, 8'h30, 8'h30, 1);   // R6 compare equal
        step(4, 8'h20, 8'h40, 1);   // R6 compare borrow
        step(5, 8'hFF, 0, 1);       // R7 inc wrap, carry kept
        step(6, 8'h00, 0, 1);       // R7 dec wrap
        step(7, 8'hF0, 8'h3C, 1);   // R8
        step(8, 8'h00, 8'h00, 1);   // R8 zero
        step(9, 8'hAA, 8'h55, 1);   // R8
        step(15, 8'h12, 0, 1);      // R11 stc
        step(10, 8'h5A, 0, 1);      // R11 not, flags kept
        step(16, 8'h12, 0, 1);      // R11 cmc
        step(16, 8'h12, 0, 1);      // R11 cmc back
        step(11, 8'h81, 0, 1);      // R9
        step(12, 8'h01, 0, 1);      // R9
        step(13, 8'h40, 0, 1);      // R10
        step(14, 8'h02, 0, 1);      // R10
        step(14, 8'h01, 0, 1);      // R10
        step(0, 8'h09, 8'h08, 1);   // R12 setup 0x11 aux
        step(17, 8'h11, 0, 1);      // R12 aux-driven adjust
        step(0, 8'h99, 8'h01, 1);
        step(17, 8'h9A, 0, 1);      // R12 both corrections
        step(17, 8'hFA, 0, 1);      // R12 carry sticks
        step(20, 8'h00, 8'h00, 1);  // R13
        step(31, 8'h80, 8'h80, 1);  // R13
        step(0, 8'hFF, 8'hFF, 0);   // R2 no commit
        step(2, 8'h00, 8'h01, 0);   // R2

        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 19), $urandom_range(0, 255), $urandom_range(0, 255), ($urandom_range(0, 7) != 0));

        step(9, 8'h81, 8'h00, 1);
        @(negedge clk) rst = 1'b1; exec_en = 0;
        @(posedge clk); #1 mflags = 0;
        chk("R1", "mid-run reset flags", flags_o, 0);
        @(negedge clk) rst = 1'b0;
        step(3, 8'h00, 8'h00, 1);   // R5 after reset, no borrow in

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule